// File: doc/BRIEF.md
# HDLC Receive Frame Checker

This block sits behind a bit-level HDLC deframer and in front of the receive buffer logic. It takes destuffed data bits one at a time, together with single-cycle indications from the surrounding receiver: a flag was seen, an abort run of ones was seen, the CRC engine found a mismatch, the receive path overran, carrier was lost, or clock recovery failed. It packs the bits into bytes, least significant bit first, and offers each byte to memory with a write strobe.

While the frame is open it counts the whole bytes it has received. It compares that count with a maximum length, which it captures when the frame opens. Bytes beyond the maximum are withheld from memory, but they are still counted, so the reported length is always the true size of the frame. When the frame ends, through a closing flag or through an error, the block emits a one-cycle close pulse. With that pulse it presents a 16-bit status word and the frame length. Both stay stable until the next close.

Top module: `hdlc_rx_frame_checker`

## Requirements
- R1: Bits are accepted only while a frame is open. A frame opens on any flag pulse. Every eighth accepted bit completes a byte, and the first bit received becomes byte bit 0. In the cycle after the bit that completes a byte, `byte_we_o` is high and `byte_o` holds that byte. Bits that arrive before any flag, or after an error close, produce no write and no close.
- R2: A flag arrives while a frame is open and at least one bit has been accepted. In the next cycle `frame_close_o` pulses for one cycle, and `frame_len_o` gives the number of complete bytes. A flag on a frame with no accepted bits produces no close.
- R3: At a flag close, status bit 11 is set if leftover bits remain that do not fill a whole byte.
- R4: The maximum length is captured from `max_len_i` at the opening flag. Later changes to that input do not affect the frame. Only the first that many bytes are written. The length reports every complete byte. Status bit 10 is set at a flag close when the count exceeds the captured maximum; a count equal to the maximum does not set it.
- R5: At a flag close, status bit 13 is set in two cases. The first is when `crc_err_i` is high in the flag cycle. The second is when the byte count is below 3 with `crc32_sel_i` low, or below 5 with it high.
- R6: An abort pulse during an open frame closes it at once with status bit 12. Later bits are ignored until the next flag.
- R7: An overrun pulse (status bit 14) or a carrier-loss pulse (status bit 15) during an open frame closes it at once. Pulses in the same cycle combine their bits, and also combine with an abort.
- R8: A clock-recovery error pulse (status bit 8) during an open frame closes it at once. That close carries bit 8 alone, whatever else arrives in the same cycle.
- R9: Status bits 0 to 7 and bit 9 are always zero. After reset all outputs are zero and no frame is open. Status and length hold their values until the next close.
- R10: If an error pulse and a flag arrive in the same cycle, the frame closes with the error status, and the flag opens a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| max_len_i | input | LEN_W | Maximum frame length in bytes, captured at the opening flag |
| crc32_sel_i | input | 1 | 1: 4-byte CRC, 0: 2-byte CRC (sets the short-frame threshold) |
| bit_valid_i | input | 1 | `bit_i` carries a destuffed data bit this cycle |
| bit_i | input | 1 | Destuffed data bit |
| flag_i | input | 1 | Flag detected (closes the open frame, opens the next) |
| abort_i | input | 1 | Run of seven or more ones detected |
| crc_err_i | input | 1 | CRC mismatch, valid in the flag cycle |
| overrun_i | input | 1 | Receive overrun |
| carrier_lost_i | input | 1 | Carrier detect dropped |
| clk_err_i | input | 1 | Clock-recovery error or missing transition |
| byte_we_o | output | 1 | Write strobe for `byte_o` |
| byte_o | output | BYTE_W | Assembled byte |
| frame_close_o | output | 1 | One-cycle frame close pulse |
| frame_status_o | output | 16 | Error status (bits 8, 10 to 15) |
| frame_len_o | output | LEN_W | Complete bytes received in the closed frame |

## Verification
The bench builds the block with its defaults, LEN_W = 12 and BYTE_W = 8. Per-frame maximum lengths run from 3 to 16 bytes. Those small limits let frames of a few bytes reach truncation, the case where the count exactly equals the maximum, and both short-frame CRC thresholds. A 12-bit counter leaves ample headroom above these sizes, so saturation of the count is not exercised; the limits are kept small to make the boundaries reachable within short frames.

// File: rtl/hdlc_chk_pkg.sv
// Package: status bit positions shared by the frame checker modules.
// Assumes a 16-bit status word with error flags in the upper byte.
package hdlc_chk_pkg;
    localparam int ST_W  = 16;
    localparam int ST_DE = 8;   // clock-recovery error
    localparam int ST_LG = 10;  // length over maximum
    localparam int ST_NO = 11;  // not a whole number of bytes
    localparam int ST_AB = 12;  // abort
    localparam int ST_CR = 13;  // CRC error or frame too short
    localparam int ST_OV = 14;  // overrun
    localparam int ST_CD = 15;  // carrier lost
    localparam int CRC16_MIN = 3;  // 2 CRC bytes + 1
    localparam int CRC32_MIN = 5;  // 4 CRC bytes + 1
endpackage

// File: rtl/hdlc_chk_byte_asm.sv
// Byte assembler: shifts in data bits least significant first and flags
// the cycle in which a byte completes. Assumes clr_i and shift_en_i are
// never high in the same cycle; clr_i wins if they are.
module hdlc_chk_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_en_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              partial_o
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr;
    logic [CW-1:0]     bit_cnt;

    assign done_o    = shift_en_i && (bit_cnt == CW'(BYTE_W - 1));
    assign byte_o    = {bit_i, sr[BYTE_W-1:1]};
    assign partial_o = (bit_cnt != '0);

    // Shift register and bit position within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sr      <= '0;
            bit_cnt <= '0;
        end else if (shift_en_i) begin
            sr      <= {bit_i, sr[BYTE_W-1:1]};
            bit_cnt <= done_o ? '0 : bit_cnt + CW'(1);
        end
    end

    // R1: a completed byte always restarts the bit position.
    a_r1_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !clr_i |=> !partial_o);
endmodule

// File: rtl/hdlc_chk_len_ctr.sv
// Length counter: counts complete bytes of the open frame with saturation,
// captures the maximum length at frame start, and reports whether the
// next byte may still be written and whether the frame is oversize.
module hdlc_chk_len_ctr #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [LEN_W-1:0] max_i,
    input  logic             inc_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] max_o,
    output logic             keep_o,
    output logic             over_o
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] max_lat;

    assign cnt_o  = cnt;
    assign max_o  = max_lat;
    assign keep_o = (cnt < max_lat);
    assign over_o = (cnt > max_lat);

    // Byte count with saturation; maximum sampled on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            max_lat <= '0;
        end else if (clr_i) begin
            cnt     <= '0;
            max_lat <= max_i;
        end else if (inc_i && (cnt != '1)) begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    // R4: the captured maximum never changes while a frame runs.
    a_r4_max_held: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> $stable(max_lat));
    // R2: the count only moves when a byte completes or a frame opens.
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !inc_i |=> $stable(cnt));
endmodule

// File: rtl/hdlc_rx_frame_checker.sv
// HDLC receive frame checker top: opens frames on flags, assembles bytes,
// gates memory writes at the maximum length, and closes frames on a flag
// or on an error with a status word and byte count. Assumes all event
// inputs are single-cycle pulses from the deframer, CRC engine and
// clock-recovery logic.
module hdlc_rx_frame_checker
    import hdlc_chk_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  max_len_i,
    input  logic              crc32_sel_i,
    input  logic              bit_valid_i,
    input  logic              bit_i,
    input  logic              flag_i,
    input  logic              abort_i,
    input  logic              crc_err_i,
    input  logic              overrun_i,
    input  logic              carrier_lost_i,
    input  logic              clk_err_i,
    output logic              byte_we_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              frame_close_o,
    output logic [ST_W-1:0]   frame_status_o,
    output logic [LEN_W-1:0]  frame_len_o
);
    logic              active;
    logic              err_hit;
    logic              shift_en;
    logic              flag_close;
    logic              close_now;
    logic              byte_done;
    logic              partial;
    logic [BYTE_W-1:0] byte_asm;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  max_lat;
    logic              keep;
    logic              over;
    logic [LEN_W-1:0]  min_len;
    logic [ST_W-1:0]   stat_n;

    // Frame events for this cycle.
    always_comb begin
        err_hit    = active && (clk_err_i || overrun_i || carrier_lost_i || abort_i);
        shift_en   = active && bit_valid_i && !flag_i && !err_hit;
        flag_close = active && flag_i && !err_hit && ((cnt != '0) || partial);
        close_now  = err_hit || flag_close;
        min_len    = crc32_sel_i ? LEN_W'(CRC32_MIN) : LEN_W'(CRC16_MIN);
    end

    // Status word for a close in this cycle, errors before flag checks.
    always_comb begin
        stat_n = '0;
        if (err_hit) begin
            if (clk_err_i) begin
                stat_n[ST_DE] = 1'b1;
            end else begin
                stat_n[ST_AB] = abort_i;
                stat_n[ST_OV] = overrun_i;
                stat_n[ST_CD] = carrier_lost_i;
            end
        end else begin
            stat_n[ST_NO] = partial;
            stat_n[ST_LG] = over;
            stat_n[ST_CR] = crc_err_i || (cnt < min_len);
        end
    end

    hdlc_chk_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (flag_i),
        .shift_en_i (shift_en),
        .bit_i      (bit_i),
        .done_o     (byte_done),
        .byte_o     (byte_asm),
        .partial_o  (partial)
    );

    hdlc_chk_len_ctr #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (flag_i),
        .max_i  (max_len_i),
        .inc_i  (byte_done),
        .cnt_o  (cnt),
        .max_o  (max_lat),
        .keep_o (keep),
        .over_o (over)
    );

    // Frame-open state: any flag opens, an error close shuts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (flag_i) begin
            active <= 1'b1;
        end else if (err_hit) begin
            active <= 1'b0;
        end
    end

    // Byte write strobe and data, gated at the captured maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_we_o <= 1'b0;
            byte_o    <= '0;
        end else begin
            byte_we_o <= byte_done && keep;
            if (byte_done) begin
                byte_o <= byte_asm;
            end
        end
    end

    // Close pulse with status and length held until the next close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_close_o  <= 1'b0;
            frame_status_o <= '0;
            frame_len_o    <= '0;
        end else begin
            frame_close_o <= close_now;
            if (close_now) begin
                frame_status_o <= stat_n;
                frame_len_o    <= cnt;
            end
        end
    end

    // R4: no byte is written past the captured maximum.
    a_r4_no_write_past_max: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we_o |-> (cnt <= max_lat));
    // R2: a close only follows a cycle in which a frame was open.
    a_r2_close_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_close_o |-> $past(active));
    // R8: a clock-recovery close reports no other error.
    a_r8_de_alone: assert property (@(posedge clk) disable iff (!rst_n)
        frame_close_o && frame_status_o[ST_DE] |-> (frame_status_o[15:9] == '0));
    // R9: unused status positions stay clear.
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_close_o |-> (frame_status_o[7:0] == '0) && !frame_status_o[9]);
    // R9: status is stable between closes.
    a_r9_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_close_o |-> $stable(frame_status_o));
endmodule

// File: tb/hdlc_rx_frame_checker_test.sv
module hdlc_rx_frame_checker_test;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] max_len = '0;
    logic             crc32_sel = 1'b0;
    logic             bit_valid = 1'b0;
    logic             bit_d = 1'b0;
    logic             flag = 1'b0;
    logic             abort_p = 1'b0;
    logic             crc_err = 1'b0;
    logic             ovr = 1'b0;
    logic             cd_lost = 1'b0;
    logic             ck_err = 1'b0;
    logic             byte_we;
    logic [7:0]       byte_q;
    logic             fclose;
    logic [15:0]      fstat;
    logic [LEN_W-1:0] flen;

    int n_chk = 0;
    int n_fail = 0;
    int close_cnt = 0;
    int we_cnt = 0;
    int data_bad = 0;
    logic [15:0]      cap_stat = '0;
    logic [LEN_W-1:0] cap_len = '0;

    hdlc_rx_frame_checker #(.LEN_W(LEN_W), .BYTE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .max_len_i(max_len), .crc32_sel_i(crc32_sel),
        .bit_valid_i(bit_valid), .bit_i(bit_d), .flag_i(flag), .abort_i(abort_p),
        .crc_err_i(crc_err), .overrun_i(ovr), .carrier_lost_i(cd_lost),
        .clk_err_i(ck_err), .byte_we_o(byte_we), .byte_o(byte_q),
        .frame_close_o(fclose), .frame_status_o(fstat), .frame_len_o(flen)
    );

    always #10 clk = ~clk;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (byte_we) begin
            if (byte_q != (8'h3C ^ 8'(we_cnt))) data_bad++;
            we_cnt++;
        end
        if (fclose) begin
            close_cnt++;
            cap_stat = fstat;
            cap_len  = flen;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        close_cnt = 0; we_cnt = 0; data_bad = 0;
    endtask

    task automatic drive_bit(input logic b);
        bit_valid = 1'b1; bit_d = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic pulse(input logic fl, input logic ab, input logic ce,
                         input logic ov, input logic cd, input logic ck);
        flag = fl; abort_p = ab; crc_err = ce; ovr = ov; cd_lost = cd; ck_err = ck;
        @(negedge clk);
        flag = 0; abort_p = 0; crc_err = 0; ovr = 0; cd_lost = 0; ck_err = 0;
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) drive_bit(((8'h3C ^ 8'(i)) >> b) & 1'b1);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [11:0] mx;
        logic        c32;
        logic [7:0]  nby;
        logic [2:0]  ext;
        logic        bad;
        logic [15:0] st;
        logic [11:0] ln;
        logic [11:0] nwe;
    } vec_t;

    // Table: max, crc32, bytes, extra bits, crc bad -> status, length, writes.
    localparam vec_t VECS [12] = '{
        '{12'd16, 1'b0, 8'd5, 3'd0, 1'b0, 16'h0000, 12'd5, 12'd5},  // R2 clean
        '{12'd16, 1'b0, 8'd5, 3'd0, 1'b1, 16'h2000, 12'd5, 12'd5},  // R5 crc bad
        '{12'd16, 1'b0, 8'd5, 3'd3, 1'b0, 16'h0800, 12'd5, 12'd5},  // R3 partial
        '{12'd4,  1'b0, 8'd6, 3'd0, 1'b0, 16'h0400, 12'd6, 12'd4},  // R4 truncate
        '{12'd6,  1'b0, 8'd6, 3'd0, 1'b0, 16'h0000, 12'd6, 12'd6},  // R4 equal max
        '{12'd6,  1'b0, 8'd7, 3'd0, 1'b0, 16'h0400, 12'd7, 12'd6},  // R4 one over
        '{12'd16, 1'b0, 8'd2, 3'd0, 1'b0, 16'h2000, 12'd2, 12'd2},  // R5 short 16
        '{12'd16, 1'b0, 8'd3, 3'd0, 1'b0, 16'h0000, 12'd3, 12'd3},  // R5 min 16
        '{12'd16, 1'b1, 8'd4, 3'd0, 1'b0, 16'h2000, 12'd4, 12'd4},  // R5 short 32
        '{12'd16, 1'b1, 8'd5, 3'd0, 1'b0, 16'h0000, 12'd5, 12'd5},  // R5 min 32
        '{12'd4,  1'b0, 8'd6, 3'd2, 1'b1, 16'h2C00, 12'd6, 12'd4},  // R3 R4 R5
        '{12'd16, 1'b0, 8'd0, 3'd5, 1'b0, 16'h2800, 12'd0, 12'd0}   // R3 R5 bits only
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R9 reset state
        check(!byte_we && !fclose && fstat == 0 && flen == 0, "R9 reset",
              {byte_we, fclose, fstat}, 0);

        // R1: bits before any flag are ignored
        clear_cap();
        send_bytes(2);
        idle(2);
        check(we_cnt == 0 && close_cnt == 0, "R1 no frame", we_cnt + close_cnt, 0);

        // R2: back-to-back flags with no data produce no close
        pulse(1, 0, 0, 0, 0, 0);
        pulse(1, 0, 0, 0, 0, 0);
        idle(2);
        check(close_cnt == 0, "R2 empty flags", close_cnt, 0);

        // Table walk
        foreach (VECS[k]) begin
            max_len = VECS[k].mx;
            crc32_sel = VECS[k].c32;
            clear_cap();
            pulse(1, 0, 0, 0, 0, 0);
            send_bytes(int'(VECS[k].nby));
            for (int e = 0; e < int'(VECS[k].ext); e++) drive_bit(e[0]);
            pulse(1, 0, VECS[k].bad, 0, 0, 0);
            idle(2);
            check(close_cnt == 1 && cap_stat == VECS[k].st, "R2 R3 R4 R5 status",
                  cap_stat, VECS[k].st);
            check(cap_len == VECS[k].ln, "R2 R4 length", cap_len, VECS[k].ln);
            check(we_cnt == int'(VECS[k].nwe) && data_bad == 0, "R1 R4 writes",
                  we_cnt, VECS[k].nwe);
        end
        crc32_sel = 1'b0;

        // R9: status and length held after close
        idle(5);
        check(fstat == 16'h2800 && flen == 0 && !fclose, "R9 hold", fstat, 16'h2800);

        // R4: maximum captured at the opening flag only
        max_len = 12'd3;
        clear_cap();
        pulse(1, 0, 0, 0, 0, 0);
        max_len = 12'd10;
        send_bytes(5);
        pulse(1, 0, 0, 0, 0, 0);
        idle(2);
        check(we_cnt == 3 && cap_stat == 16'h0400 && cap_len == 5, "R4 max sampled",
              we_cnt, 3);

        // R6: abort closes at once, later bits ignored
        max_len = 12'd16;
        clear_cap();
        pulse(1, 0, 0, 0, 0, 0);
        send_bytes(3);
        pulse(0, 1, 0, 0, 0, 0);
        idle(1);
        check(close_cnt == 1 && cap_stat == 16'h1000 && cap_len == 3, "R6 abort",
              cap_stat, 16'h1000);
        send_bytes(2);
        idle(2);
        check(we_cnt == 3 && close_cnt == 1, "R6 ignored after abort", we_cnt, 3);

        // R8: clock error with overrun reports clock error alone
        clear_cap();
        pulse(1, 0, 0, 0, 0, 0);
        send_bytes(2);
        pulse(0, 1, 0, 1, 1, 1);
        idle(2);
        check(close_cnt == 1 && cap_stat == 16'h0100 && cap_len == 2, "R8 clock error",
              cap_stat, 16'h0100);

        // R7: overrun and carrier loss combine
        clear_cap();
        pulse(1, 0, 0, 0, 0, 0);
        send_bytes(1);
        drive_bit(1'b1);
        pulse(0, 0, 0, 1, 1, 0);
        idle(2);
        check(close_cnt == 1 && cap_stat == 16'hC000 && cap_len == 1, "R7 ovr+cd",
              cap_stat, 16'hC000);

        // R10: error and flag together close, then a new frame runs
        clear_cap();
        pulse(1, 0, 0, 0, 0, 0);
        send_bytes(2);
        pulse(1, 0, 0, 1, 0, 0);
        idle(1);
        check(close_cnt == 1 && cap_stat == 16'h4000 && cap_len == 2, "R10 err close",
              cap_stat, 16'h4000);
        send_bytes(4);
        pulse(1, 0, 0, 0, 0, 0);
        idle(2);
        check(close_cnt == 2 && cap_stat == 16'h0000 && cap_len == 4, "R10 reopened",
              cap_stat, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule